// File: doc/BRIEF.md
# Register-Driven Serial EEPROM Byte Access Engine

This block lets host software read or write one byte of an external 256-byte two-wire serial EEPROM through two 32-bit registers. The command register at offset 0x58 holds the byte address, a read/write selector, a start/busy bit and a sticky error bit. The data register at offset 0x5C holds the byte to store, or the byte that was fetched. Software writes the address and type, sets the start bit, polls until the bit clears, and then checks the error bit.

A sequencer breaks each access into start, stop and byte symbols. A bit engine turns each symbol into clock and data edges at a rate set by a parameter. After a write, the sequencer probes the device with address-only transfers until it acknowledges, because the device does not respond while its internal write cycle is in progress. The register port has no handshake: it accepts a write on every clock in which `reg_we` is high and never applies back-pressure. Read data is combinational from `reg_addr`. The serial side is open-drain: the block either pulls the data line low or releases it.

Top module: `ee_byte_access`

## Requirements
- R1: After reset, both registers read 0x00000000, `scl_o` is 1 and `sda_low_o` is 0.
- R2: A command write with bit 25 = 1 and bit 24 = 0 stores data-register bits [7:0] at EEPROM byte address command bits [7:0]. On the wire the sequence is start, device address 0x50 with direction 0, byte address, data byte, stop.
- R3: A command write with bit 25 = 1 and bit 24 = 1 fetches the addressed byte into data-register bits [7:0]. On the wire the sequence is start, device address with direction 0, byte address, a repeated start, device address with direction 1, one byte ended with a not-acknowledge, and stop: two start conditions and one stop condition.
- R4: Bit 25 reads 1 from the clock after the start write until the access ends, and then reads 0.
- R5: While bit 25 reads 1, writes to the address, type and start fields and writes to the data register are ignored.
- R6: If the device does not acknowledge a device-address, byte-address or data byte, the transfer ends with a stop, bit 28 is set and bit 25 clears. A failed read leaves the data register unchanged.
- R7: Bit 28 stays set through later successful accesses. Writing 1 to bit 28 clears it, and writing 0 to it leaves it set.
- R8: After a write, bit 25 stays 1 until an address-only probe is acknowledged. If POLL_LIMIT probes go unacknowledged, bit 28 is set.
- R9: When an access fails in the same cycle as a write of 1 to bit 28, bit 28 ends up set.
- R10: Register bits outside [7:0], 24, 25 and 28 of the command register, and outside [7:0] of the data register, read as zero.
- R11: While no access is in progress, `scl_o` is 1 and `sda_low_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | AW | Register byte offset, used for both read and write |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| scl_o | output | 1 | Serial clock |
| sda_low_o | output | 1 | 1 pulls the serial data line low, 0 releases it |
| sda_in | input | 1 | Sampled level of the serial data line |

## Verification
An access that ends in failure sets the error bit, and a host write of 1 to the same bit clears it, so the two can land on the same clock edge. The bench removes the device and launches a read. It then holds a write of 1 to bit 28 on every cycle while bit 25 still reads 1, so the final edge of the failing access always carries the clear. After bit 25 falls, bit 28 must read 1; a design in which the clear wins reads 0.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_BYTE} sym_op_e;

  localparam logic [7:0] CMD_OFS = 8'h58;
  localparam logic [7:0] DAT_OFS = 8'h5C;
  localparam int BIT_TYPE = 24;
  localparam int BIT_GO   = 25;
  localparam int BIT_ERR  = 28;
endpackage

// File: rtl/ee_bitio.sv
module ee_bitio
  import ee_pkg::*;
#(
  parameter int QTR_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  sym_op_e    op,
  input  logic [7:0] tx_byte,
  input  logic       tx_ack,
  input  logic       sda_in,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       rx_nack,
  output logic       scl_o,
  output logic       sda_low_o
);
  localparam int QW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;

  logic          active;
  sym_op_e       op_q;
  logic [QW-1:0] qcnt;
  logic [1:0]    qtr;
  logic [3:0]    bitn;
  logic [8:0]    shtx, shrx;
  logic          park_scl, park_sda_low;
  logic          tick;

  assign tick    = (qcnt == QW'(QTR_CYC - 1));
  assign rx_byte = shrx[8:1];
  assign rx_nack = shrx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; op_q <= OP_STOP; qcnt <= '0; qtr <= '0; bitn <= '0;
      shtx <= '1; shrx <= '0; done <= 1'b0;
      park_scl <= 1'b1; park_sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1; op_q <= op; qcnt <= '0; qtr <= '0; bitn <= '0;
          shtx <= {tx_byte, tx_ack};
        end
      end else begin
        qcnt <= tick ? '0 : qcnt + 1'b1;
        if (tick) begin
          qtr <= qtr + 1'b1;
          if (qtr == 2'd1 && op_q == OP_BYTE) shrx <= {shrx[7:0], sda_in};
          if (qtr == 2'd3) begin
            if (op_q == OP_BYTE && bitn != 4'd8) begin
              bitn <= bitn + 1'b1;
              shtx <= {shtx[7:0], 1'b1};
            end else begin
              active <= 1'b0;
              done   <= 1'b1;
              park_scl     <= (op_q == OP_STOP);
              park_sda_low <= (op_q == OP_START);
            end
          end
        end
      end
    end
  end

  always_comb begin
    if (!active) begin
      scl_o = park_scl; sda_low_o = park_sda_low;
    end else begin
      unique case (op_q)
        OP_START: begin scl_o = (qtr == 2'd1) || (qtr == 2'd2); sda_low_o = qtr[1]; end
        OP_STOP:  begin scl_o = (qtr != 2'd0); sda_low_o = !qtr[1]; end
        default:  begin scl_o = (qtr == 2'd1) || (qtr == 2'd2); sda_low_o = !shtx[8]; end
      endcase
    end
  end
endmodule

// File: rtl/ee_seq.sv
module ee_seq
  import ee_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         POLL_LIMIT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       is_read,
  input  logic [7:0] mem_addr,
  input  logic [7:0] wr_byte,
  output logic       phy_go,
  output sym_op_e    phy_op,
  output logic [7:0] phy_tx,
  output logic       phy_ack,
  input  logic       phy_done,
  input  logic [7:0] phy_rx,
  input  logic       phy_nack,
  output logic       fin,
  output logic       fin_err,
  output logic [7:0] rd_byte
);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DEVW, S_ADDR, S_WDATA, S_RSTART, S_DEVR, S_RDATA,
    S_STOP, S_PSTART, S_PDEV, S_PSTOP
  } step_e;

  step_e         step;
  logic          issued, failed, probe_ok;
  logic [PW-1:0] probes;

  assign phy_go  = (step != S_IDLE) && !issued;
  assign phy_ack = 1'b1;

  always_comb begin
    unique case (step)
      S_START, S_RSTART, S_PSTART: phy_op = OP_START;
      S_STOP, S_PSTOP, S_IDLE:     phy_op = OP_STOP;
      default:                     phy_op = OP_BYTE;
    endcase
    unique case (step)
      S_DEVW, S_PDEV: phy_tx = {DEV_ADDR, 1'b0};
      S_DEVR:         phy_tx = {DEV_ADDR, 1'b1};
      S_ADDR:         phy_tx = mem_addr;
      S_WDATA:        phy_tx = wr_byte;
      default:        phy_tx = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= S_IDLE; issued <= 1'b0; failed <= 1'b0; probe_ok <= 1'b0;
      probes <= '0; fin <= 1'b0; fin_err <= 1'b0; rd_byte <= '0;
    end else begin
      fin <= 1'b0; fin_err <= 1'b0;
      if (step == S_IDLE) begin
        if (launch) begin
          step <= S_START; issued <= 1'b0; failed <= 1'b0; probes <= '0;
        end
      end else if (phy_done) begin
        issued <= 1'b0;
        unique case (step)
          S_START:  step <= S_DEVW;
          S_DEVW:   if (phy_nack) begin failed <= 1'b1; step <= S_STOP; end
                    else step <= S_ADDR;
          S_ADDR:   if (phy_nack) begin failed <= 1'b1; step <= S_STOP; end
                    else step <= is_read ? S_RSTART : S_WDATA;
          S_WDATA:  begin failed <= phy_nack; step <= S_STOP; end
          S_RSTART: step <= S_DEVR;
          S_DEVR:   if (phy_nack) begin failed <= 1'b1; step <= S_STOP; end
                    else step <= S_RDATA;
          S_RDATA:  begin rd_byte <= phy_rx; step <= S_STOP; end
          S_STOP:   if (failed || is_read) begin
                      fin <= 1'b1; fin_err <= failed; step <= S_IDLE;
                    end else step <= S_PSTART;
          S_PSTART: step <= S_PDEV;
          S_PDEV:   begin probe_ok <= !phy_nack; step <= S_PSTOP; end
          S_PSTOP:  if (probe_ok) begin fin <= 1'b1; step <= S_IDLE; end
                    else if (probes == PW'(POLL_LIMIT - 1)) begin
                      fin <= 1'b1; fin_err <= 1'b1; step <= S_IDLE;
                    end else begin
                      probes <= probes + 1'b1; step <= S_PSTART;
                    end
          default:  step <= S_IDLE;
        endcase
      end else if (phy_go) begin
        issued <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ee_byte_access.sv
module ee_byte_access
  import ee_pkg::*;
#(
  parameter int         AW         = 8,
  parameter int         QTR_CYC    = 8,
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         POLL_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          scl_o,
  output logic          sda_low_o,
  input  logic          sda_in
);
  logic [7:0] addr_q, data_q;
  logic       type_q, busy_q, err_q;
  logic       cmd_wr, dat_wr, launch;
  logic       phy_go, phy_ack, phy_done, phy_nack, fin, fin_err;
  sym_op_e    phy_op;
  logic [7:0] phy_tx, phy_rx, rd_byte;
  logic       unused_bits;

  assign cmd_wr = reg_we && (reg_addr == AW'(CMD_OFS));
  assign dat_wr = reg_we && (reg_addr == AW'(DAT_OFS));
  assign launch = cmd_wr && !busy_q && reg_wdata[BIT_GO];
  assign unused_bits = ^{reg_wdata[31:29], reg_wdata[27:26], reg_wdata[23:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; data_q <= '0; type_q <= 1'b0; busy_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (cmd_wr && !busy_q) begin
        addr_q <= reg_wdata[7:0];
        type_q <= reg_wdata[BIT_TYPE];
      end
      if (launch) busy_q <= 1'b1;
      if (dat_wr && !busy_q) data_q <= reg_wdata[7:0];
      if (fin) begin
        busy_q <= 1'b0;
        if (type_q && !fin_err) data_q <= rd_byte;
      end
      if (fin && fin_err) err_q <= 1'b1;
      else if (cmd_wr && reg_wdata[BIT_ERR]) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(CMD_OFS)) begin
      reg_rdata[7:0]      = addr_q;
      reg_rdata[BIT_TYPE] = type_q;
      reg_rdata[BIT_GO]   = busy_q;
      reg_rdata[BIT_ERR]  = err_q;
    end else if (reg_addr == AW'(DAT_OFS)) begin
      reg_rdata[7:0] = data_q;
    end
  end

  ee_seq #(.DEV_ADDR(DEV_ADDR), .POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .is_read(type_q),
    .mem_addr(addr_q), .wr_byte(data_q),
    .phy_go(phy_go), .phy_op(phy_op), .phy_tx(phy_tx), .phy_ack(phy_ack),
    .phy_done(phy_done), .phy_rx(phy_rx), .phy_nack(phy_nack),
    .fin(fin), .fin_err(fin_err), .rd_byte(rd_byte)
  );

  ee_bitio #(.QTR_CYC(QTR_CYC)) u_bitio (
    .clk(clk), .rst_n(rst_n), .go(phy_go), .op(phy_op), .tx_byte(phy_tx),
    .tx_ack(phy_ack), .sda_in(sda_in), .done(phy_done), .rx_byte(phy_rx),
    .rx_nack(phy_nack), .scl_o(scl_o), .sda_low_o(sda_low_o)
  );
endmodule

// File: rtl/ee_byte_access_chk.sv
module ee_byte_access_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic       go_bit,
  input logic       err_bit,
  input logic       busy_q,
  input logic       err_q,
  input logic [7:0] addr_q,
  input logic       type_q,
  input logic       scl_o,
  input logic       sda_low_o
);
  // R4
  busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cmd_wr && go_bit));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(addr_q) && $stable(type_q)));

  // R6
  err_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $fell(busy_q));

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(cmd_wr && err_bit));

  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (scl_o && !sda_low_o));
endmodule

bind ee_byte_access ee_byte_access_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .go_bit(reg_wdata[25]),
  .err_bit(reg_wdata[28]), .busy_q(busy_q), .err_q(err_q), .addr_q(addr_q),
  .type_q(type_q), .scl_o(scl_o), .sda_low_o(sda_low_o)
);

// File: tb/test_ee_byte_access.sv
`timescale 1ns/1ps
module test_ee_byte_access;
  localparam logic [7:0] CMD = 8'h58;
  localparam logic [7:0] DAT = 8'h5C;
  localparam int NVEC = 9;
  // {read, address, data}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 8'hA5}, {1'b0, 8'hFF, 8'h3C}, {1'b0, 8'h10, 8'h00},
    {1'b1, 8'h00, 8'hA5}, {1'b1, 8'hFF, 8'h3C}, {1'b1, 8'h10, 8'h00},
    {1'b1, 8'h77, 8'h2D}, {1'b0, 8'h77, 8'hFF}, {1'b1, 8'h77, 8'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic scl_o, sda_low_o;
  logic ack_drv = 1'b0, rd_drv = 1'b0;
  wire sda_line = !(sda_low_o | ack_drv | rd_drv);
  int n_chk = 0, n_err = 0, n_start = 0, n_stop = 0;
  int busy_cfg = 0, busy_left = 0;
  logic present = 1'b1, finished = 1'b0;
  logic [7:0] mem [256];

  always #4 clk = !clk;

  ee_byte_access #(.QTR_CYC(2), .POLL_LIMIT(8)) i_ee_byte_access (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_o(scl_o),
    .sda_low_o(sda_low_o), .sda_in(sda_line)
  );

  // Serial EEPROM model, one process
  initial begin
    logic ps, pc, in_ack, acked, rw, wrote, ack;
    logic [7:0] sh, ptr, outb;
    int ph, bc;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    ps = 1; pc = 1; in_ack = 0; acked = 0; rw = 0; wrote = 0;
    sh = 0; ptr = 0; outb = 0; ph = 4; bc = 0;
    forever begin
      @(sda_line or scl_o);
      if (scl_o && pc && sda_line !== ps) begin
        ack_drv = 0; rd_drv = 0; in_ack = 0; bc = 0;
        if (!sda_line) begin n_start++; ph = 0; end
        else begin
          n_stop++; ph = 4;
          if (wrote) begin busy_left = busy_cfg; wrote = 0; end
        end
      end else if (scl_o && !pc) begin
        if (ph <= 2 && !in_ack && bc < 8) begin sh = {sh[6:0], sda_line}; bc++; end
        else if (ph == 3) begin if (bc == 8) ph = 4; else bc++; end
      end else if (!scl_o && pc) begin
        if (in_ack) begin
          in_ack = 0; ack_drv = 0;
          if (!acked) ph = 4;
          else if (ph == 0 && rw) begin ph = 3; outb = mem[ptr]; bc = 0; rd_drv = !outb[7]; end
          else if (ph == 0) ph = 1;
          else if (ph == 1) ph = 2;
          else ph = 4;
        end else if (ph <= 2 && bc == 8) begin
          ack = 1;
          if (ph == 0) begin
            rw = sh[0];
            ack = present && sh[7:1] == 7'h50 && (busy_left == 0 || busy_cfg == 0);
            if (!ack && busy_left > 0) busy_left--;
          end else if (ph == 1) ptr = sh;
          else begin mem[ptr] = sh; wrote = 1; end
          in_ack = 1; acked = ack; ack_drv = ack; bc = 0;
        end else if (ph == 3) rd_drv = (bc < 8) ? !outb[7-bc] : 1'b0;
      end
      ps = sda_line; pc = scl_o;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic launch(input logic r, input logic [7:0] a, input logic [7:0] d);
    logic [31:0] v;
    if (!r) wr(DAT, {24'h0, d});
    wr(CMD, {7'h0, r, 16'h0, a} | 32'h0200_0000);
    rd(CMD, v);
    check("R4 busy after start", {31'h0, v[25]}, 32'h1);
  endtask

  task automatic wait_done(output logic [31:0] v);
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk); rd(CMD, v);
      if (!v[25]) break;
    end
  endtask

  initial begin
    logic [31:0] v, d;
    repeat (3) @(negedge clk);
    rd(CMD, v); check("R1 cmd reset", v, 0);
    rd(DAT, v); check("R1 data reset", v, 0);
    check("R1 bus idle", {30'h0, scl_o, sda_low_o}, 32'h2);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // vector walk, R2 writes / R3 reads
    for (int i = 0; i < NVEC; i++) begin
      busy_cfg = 2;
      launch(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
      wait_done(v);
      check("R4 busy clears", {31'h0, v[25]}, 0);
      check("R6 no error on good access", {31'h0, v[28]}, 0);
      if (VEC[i][16]) begin
        rd(DAT, d); check("R3 read byte", d, {24'h0, VEC[i][7:0]});
      end else begin
        check("R2 stored byte", {24'h0, mem[VEC[i][15:8]]}, {24'h0, VEC[i][7:0]});
        check("R8 probed until ack", busy_left, 0);
      end
    end
    check("R11 idle after access", {30'h0, scl_o, sda_low_o}, 32'h2);

    // R3 framing
    busy_cfg = 0; n_start = 0; n_stop = 0;
    launch(1, 8'h42, 0); wait_done(v);
    check("R3 start count", n_start, 2);
    check("R3 stop count", n_stop, 1);
    // R2 framing: one write plus one probe
    n_start = 0; n_stop = 0;
    launch(0, 8'h43, 8'h11); wait_done(v);
    check("R2 start count", n_start, 2);
    check("R2 stop count", n_stop, 2);

    // R5 writes ignored while busy
    launch(1, 8'h00, 0);
    wr(CMD, 32'h0200_0033); wr(DAT, 32'h99);
    wait_done(v);
    check("R5 address held", {24'h0, v[7:0]}, 32'h00);
    check("R5 type held", {31'h0, v[24]}, 1);
    rd(DAT, d); check("R5 data not overwritten", d, 32'hA5);

    // R10 unused bits
    wr(CMD, 32'hECFF_FF12); rd(CMD, v); check("R10 cmd unused zero", v, 32'h12);
    wr(DAT, 32'hFFFF_FF81); rd(DAT, v); check("R10 data unused zero", v, 32'h81);

    // R6 missing device
    present = 0;
    launch(1, 8'h05, 0); wait_done(v);
    check("R6 error set", {31'h0, v[28]}, 1);
    check("R6 busy clear", {31'h0, v[25]}, 0);
    rd(DAT, d); check("R6 data unchanged", d, 32'h81);
    present = 1;

    // R7 sticky and write-1-to-clear
    launch(1, 8'h00, 0); wait_done(v);
    check("R7 sticky over good access", {31'h0, v[28]}, 1);
    wr(CMD, 32'h0); rd(CMD, v);
    check("R7 zero write keeps", {31'h0, v[28]}, 1);
    wr(CMD, 32'h1000_0000); rd(CMD, v);
    check("R7 one write clears", {31'h0, v[28]}, 0);

    // R8 probe limit
    busy_cfg = 1000;
    launch(0, 8'h20, 8'h66); wait_done(v);
    check("R8 probe limit error", {31'h0, v[28]}, 1);
    busy_cfg = 0;
    wr(CMD, 32'h1000_0000);

    // R9 failure and clear on the same edge
    present = 0;
    launch(1, 8'h01, 0);
    reg_addr = CMD; reg_wdata = 32'h1000_0000; reg_we = 1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk); #1;
      if (!reg_rdata[25]) break;
    end
    reg_we = 0;
    rd(CMD, v); check("R9 set beats clear", {31'h0, v[28]}, 1);
    present = 1;
    check("R11 idle at end", {30'h0, scl_o, sda_low_o}, 32'h2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule